// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block walks an SDRAM or DDR SDRAM device through its start-up command sequence. The sequence runs after reset or after a one-cycle restart request. It begins with a precharge of all banks. In DDR mode it then loads the extended mode register. Next it loads the mode register with the DLL-reset bit set, issues a second precharge of all banks and a configurable number of auto-refresh commands (two by default). It ends with a final load of the mode register that has the DLL-reset bit cleared.

Each command is presented for one cycle on a command bus together with a register-select code and a mode value. The sequencer then waits for a completion pulse from the external command timer before it moves to the next step. The memory type and both mode values come from configuration inputs. When the last step completes, an init-done flag rises and stays set. Normal memory access requests are granted only while that flag is set.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, `cmd_valid`, `init_done` and `acc_grant` are 0, and `cmd_code`, `mr_sel` and `mr_value` are all zero. The first command pulse appears in the cycle after the first rising edge at which `rst` is low.
- R2: With `cfg_ddr`=1 the commands come out in this order: precharge-all, extended load, DLL load, precharge-all, REF_COUNT refreshes, final load. That is 7 commands with the default REF_COUNT=2.
- R3: With `cfg_ddr`=0 the extended load is left out, giving 6 commands by default, and no command ever carries `mr_sel`=01.
- R4: The register select is the pair of upper mode-field bits and is driven on `mr_sel`. It is 01 for the extended mode register, and the extended load carries `cfg_emode` on `mr_value`. It is 00 for the main mode register.
- R5: The first main-register load drives `cfg_mode` with bit DLL_BIT (default 8) forced to 1. The final load drives `cfg_mode` with that bit forced to 0.
- R6: Every command is a single-cycle `cmd_valid` pulse. Command codes are 0 idle, 1 precharge-all, 2 load mode register and 3 auto-refresh. `cmd_code` is 0 whenever `cmd_valid` is low, and `mr_sel`/`mr_value` are 0 for commands other than a load.
- R7: `step_done` is accepted at the clock edge that ends a pulse cycle or at any later edge. The next pulse appears two cycles after the pulse cycle plus the number of cycles `step_done` was held back.
- R8: `init_done` rises in the cycle after the edge that accepts the final load, and stays high with no further commands until a restart.
- R9: `acc_grant` is `acc_req` registered and gated by `init_done` from the previous cycle, so no access is granted before initialization ends.
- R10: A `start` pulse, or `rst`, at any point clears `init_done` and restarts the sequence from the first step. The first pulse follows one cycle after the restart edge.
- R11: `step_done` pulses while no command is outstanding after completion have no effect: there are no command pulses and `init_done` stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle restart request |
| cfg_ddr | input | 1 | 1 selects DDR, 0 selects single-data-rate SDRAM |
| cfg_mode | input | MODE_W | Main mode register value |
| cfg_emode | input | MODE_W | Extended mode register value |
| step_done | input | 1 | Command timer reports the current step complete |
| acc_req | input | 1 | Normal access request |
| cmd_valid | output | 1 | Command strobe, one cycle per command |
| cmd_code | output | 2 | Command code |
| mr_sel | output | 2 | Mode register select (upper mode-field bits) |
| mr_value | output | MODE_W | Mode register value |
| init_done | output | 1 | Initialization complete |
| acc_grant | output | 1 | Registered access grant |

## Verification
The assertions assume that `cfg_ddr`, `cfg_mode` and `cfg_emode` change only while `rst` is held, and that the timer raises `step_done` only in answer to a command pulse. The bench sets up the configuration under reset for each run. It models the timer as a single `step_done` pulse placed a fixed latency after each command, and sweeps both memory types, latencies 0 to 3 and several mode patterns. The only `step_done` pulses that fall outside that rule are injected on purpose after completion, to show that they are ignored.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  typedef enum logic [1:0] {
    CMD_NOP       = 2'd0,
    CMD_PRE_ALL   = 2'd1,
    CMD_LOAD_MODE = 2'd2,
    CMD_REFRESH   = 2'd3
  } dram_cmd_e;

  typedef enum logic [2:0] {
    ST_PRE_A,
    ST_EMR,
    ST_MRS_DLL,
    ST_PRE_B,
    ST_REF,
    ST_MRS_FINAL,
    ST_DONE
  } init_step_e;

  localparam logic [1:0] SEL_MAIN = 2'b00;
  localparam logic [1:0] SEL_EXT  = 2'b01;
endpackage

// File: rtl/init_step_ctrl.sv
module init_step_ctrl
  import sdram_init_pkg::*;
#(
  parameter int REF_COUNT = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       ddr,
  input  logic       step_done,
  output init_step_e step,
  output logic       issue,
  output logic       done
);
  localparam int RCW = (REF_COUNT > 1) ? $clog2(REF_COUNT) : 1;
  localparam logic [RCW-1:0] REF_LAST = RCW'(REF_COUNT - 1);

  logic           waiting;
  logic [RCW-1:0] ref_cnt;
  init_step_e     nxt;

  always_comb begin
    nxt = step;
    case (step)
      ST_PRE_A:     nxt = ddr ? ST_EMR : ST_MRS_DLL;
      ST_EMR:       nxt = ST_MRS_DLL;
      ST_MRS_DLL:   nxt = ST_PRE_B;
      ST_PRE_B:     nxt = ST_REF;
      ST_REF:       nxt = (ref_cnt == REF_LAST) ? ST_MRS_FINAL : ST_REF;
      ST_MRS_FINAL: nxt = ST_DONE;
      default:      nxt = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      step    <= ST_PRE_A;
      waiting <= 1'b0;
      ref_cnt <= '0;
      done    <= 1'b0;
    end else if (step != ST_DONE) begin
      if (!waiting) begin
        waiting <= 1'b1;
      end else if (step_done) begin
        waiting <= 1'b0;
        step    <= nxt;
        if (step == ST_REF)
          ref_cnt <= (nxt == ST_REF) ? ref_cnt + RCW'(1) : '0;
        if (nxt == ST_DONE)
          done <= 1'b1;
      end
    end
  end

  assign issue = !waiting && (step != ST_DONE);
endmodule

// File: rtl/init_step_decode.sv
module init_step_decode
  import sdram_init_pkg::*;
#(
  parameter int MODE_W  = 14,
  parameter int DLL_BIT = 8
) (
  input  init_step_e        step,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [MODE_W-1:0] cfg_emode,
  output dram_cmd_e         cmd,
  output logic [1:0]        sel,
  output logic [MODE_W-1:0] value
);
  localparam logic [MODE_W-1:0] DLL_MASK = MODE_W'(1) << DLL_BIT;

  always_comb begin
    cmd   = CMD_NOP;
    sel   = SEL_MAIN;
    value = '0;
    case (step)
      ST_PRE_A, ST_PRE_B: cmd = CMD_PRE_ALL;
      ST_REF:             cmd = CMD_REFRESH;
      ST_EMR: begin
        cmd   = CMD_LOAD_MODE;
        sel   = SEL_EXT;
        value = cfg_emode;
      end
      ST_MRS_DLL: begin
        cmd   = CMD_LOAD_MODE;
        value = cfg_mode | DLL_MASK;
      end
      ST_MRS_FINAL: begin
        cmd   = CMD_LOAD_MODE;
        value = cfg_mode & ~DLL_MASK;
      end
      default: cmd = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int MODE_W    = 14,
  parameter int DLL_BIT   = 8,
  parameter int REF_COUNT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cfg_ddr,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [MODE_W-1:0] cfg_emode,
  input  logic              step_done,
  input  logic              acc_req,
  output logic              cmd_valid,
  output logic [1:0]        cmd_code,
  output logic [1:0]        mr_sel,
  output logic [MODE_W-1:0] mr_value,
  output logic              init_done,
  output logic              acc_grant
);
  init_step_e        cur_step;
  logic              issue;
  logic              done_q;
  dram_cmd_e         dec_cmd;
  logic [1:0]        dec_sel;
  logic [MODE_W-1:0] dec_value;

  init_step_ctrl #(.REF_COUNT(REF_COUNT)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ddr       (cfg_ddr),
    .step_done (step_done),
    .step      (cur_step),
    .issue     (issue),
    .done      (done_q)
  );

  init_step_decode #(.MODE_W(MODE_W), .DLL_BIT(DLL_BIT)) u_dec (
    .step      (cur_step),
    .cfg_mode  (cfg_mode),
    .cfg_emode (cfg_emode),
    .cmd       (dec_cmd),
    .sel       (dec_sel),
    .value     (dec_value)
  );

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cmd_valid <= 1'b0;
      cmd_code  <= CMD_NOP;
      mr_sel    <= '0;
      mr_value  <= '0;
      acc_grant <= 1'b0;
    end else begin
      cmd_valid <= issue;
      cmd_code  <= issue ? dec_cmd : CMD_NOP;
      mr_sel    <= issue ? dec_sel : '0;
      mr_value  <= issue ? dec_value : '0;
      acc_grant <= acc_req && done_q;
    end
  end

  assign init_done = done_q;
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk
  import sdram_init_pkg::*;
#(
  parameter int MODE_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              cfg_ddr,
  input logic              acc_req,
  input logic              cmd_valid,
  input logic [1:0]        cmd_code,
  input logic [1:0]        mr_sel,
  input logic [MODE_W-1:0] mr_value,
  input logic              init_done,
  input logic              acc_grant
);
  // R6: single-cycle strobe
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  // R6: idle code while no strobe
  a_r6_idle_code: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |-> cmd_code == 2'd0);

  // R6: select and value are zero except on loads
  a_r6_quiet_bus: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code != 2'd2) |-> (mr_sel == 2'b00 && mr_value == '0));

  // R3: extended register is touched only in DDR mode
  a_r3_no_ext_sdr: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && mr_sel == SEL_EXT) |-> cfg_ddr);

  // R8: no command once complete, and completion holds
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
    init_done |-> !cmd_valid);
  a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
    (init_done && !start) |=> init_done);

  // R9: grant only after completion
  a_r9_grant_gated: assert property (@(posedge clk) disable iff (rst)
    acc_grant |-> ($past(init_done) && $past(acc_req)));

  // R10: restart clears completion and the strobe
  a_r10_restart: assert property (@(posedge clk) disable iff (rst)
    start |=> (!init_done && !cmd_valid && !acc_grant));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(.MODE_W(MODE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .cfg_ddr   (cfg_ddr),
  .acc_req   (acc_req),
  .cmd_valid (cmd_valid),
  .cmd_code  (cmd_code),
  .mr_sel    (mr_sel),
  .mr_value  (mr_value),
  .init_done (init_done),
  .acc_grant (acc_grant)
);

// File: tb/sdram_init_seq_test.sv
`timescale 1ns/1ps
module sdram_init_seq_test;
  localparam int MW = 14;
  localparam int DB = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst, start, cfg_ddr, step_done, acc_req;
  logic [MW-1:0] cfg_mode, cfg_emode;
  logic          cmd_valid, init_done, acc_grant;
  logic [1:0]    cmd_code, mr_sel;
  logic [MW-1:0] mr_value;

  int n_chk = 0;
  int n_bad = 0;

  sdram_init_seq #(.MODE_W(MW), .DLL_BIT(DB), .REF_COUNT(2)) uut (
    .clk(clk), .rst(rst), .start(start), .cfg_ddr(cfg_ddr),
    .cfg_mode(cfg_mode), .cfg_emode(cfg_emode), .step_done(step_done),
    .acc_req(acc_req), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .mr_sel(mr_sel), .mr_value(mr_value), .init_done(init_done),
    .acc_grant(acc_grant)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Follows one sequence from its first pulse; the timer answers each
  // pulse after lat cycles. stop_after > 0 leaves after that many pulses.
  task automatic capture(input bit ddr, input int lat, input logic [MW-1:0] m,
                         input logic [MW-1:0] em, input int stop_after);
    logic [1:0]    ec[8];
    logic [1:0]    es[8];
    logic [MW-1:0] ev[8];
    logic [MW-1:0] dll;
    int n_exp = 0;
    int cyc = 0, np = 0, due = -1, next_at = 0;
    bit prev_done = 1'b0, seen = 1'b0, quit = 1'b0;
    dll = MW'(1) << DB;
    ec[n_exp] = 2'd1; es[n_exp] = 2'b00; ev[n_exp] = '0; n_exp++;
    if (ddr) begin ec[n_exp] = 2'd2; es[n_exp] = 2'b01; ev[n_exp] = em; n_exp++; end
    ec[n_exp] = 2'd2; es[n_exp] = 2'b00; ev[n_exp] = m | dll;  n_exp++;
    ec[n_exp] = 2'd1; es[n_exp] = 2'b00; ev[n_exp] = '0;       n_exp++;
    ec[n_exp] = 2'd3; es[n_exp] = 2'b00; ev[n_exp] = '0;       n_exp++;
    ec[n_exp] = 2'd3; es[n_exp] = 2'b00; ev[n_exp] = '0;       n_exp++;
    ec[n_exp] = 2'd2; es[n_exp] = 2'b00; ev[n_exp] = m & ~dll; n_exp++;
    while (cyc < 400 && !seen && !quit) begin
      @(negedge clk);
      step_done = 1'b0;
      chk(acc_grant == prev_done, "R9", "grant", acc_grant, prev_done);
      if (cmd_valid) begin
        chk(np < n_exp, ddr ? "R2" : "R3", "extra pulse", np, n_exp);
        if (np < n_exp) begin
          chk(cmd_code == ec[np], ddr ? "R2" : "R3", "cmd", cmd_code, ec[np]);
          chk(mr_sel == es[np], "R4", "sel", mr_sel, es[np]);
          chk(mr_value == ev[np], (ec[np] == 2'd2 && es[np] == 2'b00) ? "R5" : "R4",
              "value", mr_value, ev[np]);
          chk(cyc == next_at, (np == 0) ? "R1" : "R7", "pulse cycle", cyc, next_at);
        end
        np++;
        due = cyc + lat;
        next_at = cyc + lat + 2;
        if (stop_after > 0 && np == stop_after) quit = 1'b1;
      end else begin
        chk(cmd_code == 2'd0, "R6", "idle code", cmd_code, 0);
      end
      if (init_done) begin
        seen = 1'b1;
        chk(np == n_exp, ddr ? "R2" : "R3", "pulse count", np, n_exp);
        chk(cyc == due + 1, "R8", "done cycle", cyc, due + 1);
      end
      if (cyc == due && !init_done && !quit) step_done = 1'b1;
      prev_done = init_done;
      cyc++;
    end
    if (stop_after <= 0) chk(seen, "R8", "done reached", seen, 1);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    chk(init_done == 1'b0, "R10", "done under reset", init_done, 0);
    @(negedge clk);
    chk(cmd_valid == 1'b0 && acc_grant == 1'b0, "R1", "outputs under reset",
        {cmd_valid, acc_grant}, 0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [MW-1:0] mp[3];
    logic [MW-1:0] ep[3];
    mp[0] = 14'h0023; mp[1] = 14'h3FFF; mp[2] = 14'h0000;
    ep[0] = 14'h0000; ep[1] = 14'h2AAA; ep[2] = 14'h0155;
    rst = 1'b1; start = 1'b0; step_done = 1'b0; acc_req = 1'b0;
    cfg_ddr = 1'b1; cfg_mode = mp[0]; cfg_emode = ep[0];
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_valid == 0 && init_done == 0 && acc_grant == 0, "R1", "flags",
        {cmd_valid, init_done, acc_grant}, 0);
    chk(cmd_code == 0 && mr_sel == 0 && mr_value == 0, "R1", "buses",
        {cmd_code, mr_sel, mr_value}, 0);

    for (int d = 0; d < 2; d++) begin
      for (int lat = 0; lat < 4; lat++) begin
        for (int p = 0; p < 3; p++) begin
          cfg_ddr = d[0]; cfg_mode = mp[p]; cfg_emode = ep[p]; acc_req = 1'b1;
          do_reset();
          capture(d[0], lat, mp[p], ep[p], 0);
          // R11 stray completions after the sequence
          for (int k = 0; k < 3; k++) begin
            step_done = 1'b1;
            @(negedge clk);
            step_done = 1'b0;
            chk(cmd_valid == 0 && init_done == 1, "R11", "stray done",
                {cmd_valid, init_done}, 1);
          end
          acc_req = 1'b0;
          @(negedge clk);
          chk(acc_grant == 0, "R9", "grant drop", acc_grant, 0);
        end
      end
    end

    // R10 start in mid sequence
    cfg_ddr = 1'b1; cfg_mode = mp[0]; cfg_emode = ep[1]; acc_req = 1'b1;
    do_reset();
    capture(1'b1, 1, mp[0], ep[1], 3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cmd_valid == 0 && init_done == 0, "R10", "after start",
        {cmd_valid, init_done}, 0);
    capture(1'b1, 1, mp[0], ep[1], 0);

    // R10 start after completion
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(init_done == 0 && acc_grant == 0, "R10", "start clears done",
        {init_done, acc_grant}, 0);
    capture(1'b1, 2, mp[0], ep[1], 0);

    // R10 reset in mid sequence
    cfg_ddr = 1'b0;
    do_reset();
    capture(1'b0, 0, mp[0], ep[1], 4);
    do_reset();
    capture(1'b0, 3, mp[0], ep[1], 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule